// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block decides, one clock at a time, whether another copy of the same instruction may enter a non-linear pipeline. In such a pipeline some hardware stages are used more than once, or for several cycles, by a single instruction. Which start distances are unsafe is described by a collision vector. Bit `i` of `cv_in` set to 1 means that starting a new instruction `i+1` cycles after an earlier one would make both claim the same stage in the same cycle. A 0 bit only means there is no clash at that distance; it does not mean that distance gives good throughput.

The controller keeps a status shift register that holds the unsafe distances of every instruction still in flight. On each initiation it merges the collision vector into that register. It offers two start policies:

- **Greedy** starts at the first safe cycle.
- **Fixed-latency** waits at least `fixed_lat` cycles after the previous start. When that distance is safe it starts exactly there. If not, it slides to the next safe cycle.

The fixed policy exists because the earliest safe start can lower throughput compared with a regular, later one.

Requests use a valid/ready handshake. `req_ready` never depends on `req_valid`. A requester raises `req_valid` and must hold it until a cycle with `req_ready` high; that cycle is the initiation. The configuration inputs are plain pins. They are meant to change only while `rst` is held.

Top module: `cv_issue_ctrl`

## Requirements
- R1: A synchronous reset clears the in-flight status and sets `init_count` to 0. The first request after reset initiates in its first valid cycle, whatever was in flight before the reset.
- R2: `init_fire` is high exactly in the cycles where `req_valid` and `req_ready` are both high. `req_ready` does not depend on `req_valid`, and no initiation happens without `req_valid`.
- R3: When an initiation happens in cycle t and `cv_in[i]` is 1 (with i+1 < `cv_len`), `req_ready` is low in cycle t+i+1. The status of all in-flight initiations is merged, so any one of them can block a cycle.
- R4: With `policy` = 0 (greedy), a pending request initiates in the first cycle in which no in-flight initiation blocks it.
- R5: `cv_len` gives the pipeline length n. Bits of `cv_in` at index n-1 or above are ignored. A start n or more cycles after the latest initiation is never blocked.
- R6: With `policy` = 1 (fixed), a start needs at least `fixed_lat` cycles since the previous initiation as well as a free status. When that distance is free and the request is pending, the start happens exactly `fixed_lat` cycles later. Otherwise it happens at the next free cycle.
- R7: Under the fixed policy, the first initiation after reset is not held back by `fixed_lat`.
- R8: `init_count` rises by exactly one per initiation, holds otherwise, and wraps modulo 2^CNT_W.
- R9: Take n = 8 with unsafe distances 2, 4 and 5, and a request held high from reset:
  - greedy makes 6 initiations in the first 21 cycles;
  - fixed latency 3 makes 7 initiations in the same 21 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cv_in | input | MAX_LEN-1 | Collision vector; bit i forbids start distance i+1 |
| cv_len | input | LAT_W | Pipeline length n in cycles |
| policy | input | 1 | 0 greedy, 1 fixed latency |
| fixed_lat | input | LAT_W | Target start distance for the fixed policy |
| req_valid | input | 1 | Request to initiate; held until accepted |
| req_ready | output | 1 | Initiation permitted this cycle |
| init_fire | output | 1 | Initiation strobe (valid and ready) |
| init_count | output | CNT_W | Number of initiations since reset, wrapping |

## Verification
The properties assume three things about the inputs:
- `cv_in`, `cv_len`, `policy` and `fixed_lat` stay constant from one reset to the next;
- `cv_len` does not exceed MAX_LEN;
- a raised `req_valid` is held until it is accepted.

If the configuration changed while instructions were in flight, the merged status would mix two vectors, and the check that aged starts are free would no longer apply. The stimulus therefore writes each new configuration and then applies a reset before any request. The pseudo-random request pattern only raises new requests and keeps any pending one asserted until it fires.

// File: rtl/cvi_pkg.sv
package cvi_pkg;
  typedef enum logic {
    POL_GREEDY = 1'b0,
    POL_FIXED  = 1'b1
  } issue_pol_e;
endpackage

// File: rtl/cvi_status_reg.sv
module cvi_status_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] cv_eff,
  output logic         blocked
);
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;

  // Slot k of the status means "a start k cycles from now is forbidden".
  // Each cycle the slots move one place closer; an initiation merges the
  // collision vector into the slots that follow it.
  generate
    for (genvar i = 0; i < W; i++) begin : g_slot
      if (i == W - 1) begin : g_top
        assign status_d[i] = load & cv_eff[i];
      end else begin : g_mid
        assign status_d[i] = status_q[i+1] | (load & cv_eff[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  assign blocked = status_q[0];

  // R3
  stat_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> ((status_q & $past(cv_eff)) == $past(cv_eff)));

  // R1
  stat_clear_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0));
endmodule

// File: rtl/cvi_gap_timer.sv
module cvi_gap_timer #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  output logic             started,
  output logic [LAT_W-1:0] elapsed
);
  localparam logic [LAT_W-1:0] ELAP_MAX = '1;

  logic             started_q;
  logic [LAT_W-1:0] elapsed_q;

  // Counts cycles since the latest initiation, saturating at ELAP_MAX.
  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      elapsed_q <= '0;
    end else if (fire) begin
      started_q <= 1'b1;
      elapsed_q <= LAT_W'(1);
    end else if (started_q && (elapsed_q != ELAP_MAX)) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign started = started_q;
  assign elapsed = elapsed_q;
endmodule

// File: rtl/cvi_issue_gate.sv
module cvi_issue_gate
  import cvi_pkg::*;
#(
  parameter int LAT_W = 5
) (
  input  logic             blocked,
  input  logic             started,
  input  issue_pol_e       pol,
  input  logic [LAT_W-1:0] elapsed,
  input  logic [LAT_W-1:0] fixed_lat,
  output logic             may_issue
);
  always_comb begin
    may_issue = !blocked;
    if ((pol == POL_FIXED) && started && (elapsed < fixed_lat)) begin
      may_issue = 1'b0;
    end
  end
endmodule

// File: rtl/cvi_init_counter.sv
module cvi_init_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)      count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  assign count = count_q;

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> (count_q == $past(count_q) + 1'b1));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count_q));
endmodule

// File: rtl/cv_issue_ctrl.sv
module cv_issue_ctrl
  import cvi_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 16,
  parameter int LAT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MAX_LEN-2:0] cv_in,
  input  logic [LAT_W-1:0]   cv_len,
  input  logic               policy,
  input  logic [LAT_W-1:0]   fixed_lat,
  input  logic               req_valid,
  output logic               req_ready,
  output logic               init_fire,
  output logic [CNT_W-1:0]   init_count
);
  localparam int W = MAX_LEN - 1;

  logic [W-1:0]     cv_eff;
  logic             blocked;
  logic             started;
  logic [LAT_W-1:0] elapsed;
  logic             may_issue;
  issue_pol_e       pol_sel;

  assign pol_sel = issue_pol_e'(policy);

  // Drop vector bits at or beyond the pipeline length.
  generate
    for (genvar i = 0; i < W; i++) begin : g_mask
      localparam logic [LAT_W-1:0] DIST = LAT_W'(i + 1);
      assign cv_eff[i] = cv_in[i] & (DIST < cv_len);
    end
  endgenerate

  cvi_status_reg #(.W(W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .load    (init_fire),
    .cv_eff  (cv_eff),
    .blocked (blocked)
  );

  cvi_gap_timer #(.LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .fire    (init_fire),
    .started (started),
    .elapsed (elapsed)
  );

  cvi_issue_gate #(.LAT_W(LAT_W)) u_gate (
    .blocked   (blocked),
    .started   (started),
    .pol       (pol_sel),
    .elapsed   (elapsed),
    .fixed_lat (fixed_lat),
    .may_issue (may_issue)
  );

  cvi_init_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (init_fire),
    .count (init_count)
  );

  assign req_ready = may_issue;
  assign init_fire = req_valid & may_issue;

  // R5
  aged_free_chk: assert property (@(posedge clk) disable iff (rst)
    (started && (elapsed >= cv_len)) |-> !blocked);

  // R4
  greedy_take_chk: assert property (@(posedge clk) disable iff (rst)
    ((pol_sel == POL_GREEDY) && req_valid && !blocked) |-> init_fire);

  // R6
  fixed_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (init_fire && (pol_sel == POL_FIXED) && started) |-> (elapsed >= fixed_lat));
endmodule

// File: tb/cv_issue_ctrl_test.sv
module cv_issue_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cv_in = '0;
  logic [3:0] cv_len = 4'd8;
  logic       policy = 1'b0;
  logic [3:0] fixed_lat = 4'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       init_fire;
  logic [7:0] init_count;

  int checks = 0;
  int bad = 0;
  int t, last_t, mcount;
  bit have_prev, pend;
  logic [7:0]  hist;
  logic [15:0] lfsr = 16'hACE1;

  cv_issue_ctrl #(.MAX_LEN(8), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .cv_in(cv_in), .cv_len(cv_len), .policy(policy),
    .fixed_lat(fixed_lat), .req_valid(req_valid), .req_ready(req_ready),
    .init_fire(init_fire), .init_count(init_count)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at t=%0d: actual %0d expected %0d", tag, what, t, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(init_count == 8'd0, "R1", "count after reset", int'(init_count), 0);
    t = 0; last_t = 0; mcount = 0; have_prev = 0; pend = 0; hist = '0;
  endtask

  task automatic run(input logic [6:0] cv, input logic [3:0] len, input logic pol,
                     input logic [3:0] lat, input int ncyc, input bit rand_req,
                     input string tag);
    bit v, perm, gap, exp;
    cv_in = cv; cv_len = len; policy = pol; fixed_lat = lat;
    do_reset();
    for (int c = 0; c < ncyc; c++) begin
      if (c != 0) @(negedge clk);
      v = pend || !rand_req || lfsr[0];
      req_valid = v;
      #1;
      perm = 1'b1;
      for (int k = 1; k < 8; k++)
        if (hist[k] && (k < int'(len)) && cv[k-1]) perm = 1'b0;
      gap = (pol == 1'b0) || !have_prev || ((t - last_t) >= int'(lat));
      exp = v && perm && gap;
      check(req_ready == (perm && gap), "R3", "ready", int'(req_ready), int'(perm && gap));
      check(init_fire == exp, v ? tag : "R2", "fire", int'(init_fire), int'(exp));
      check(init_count == mcount[7:0], "R8", "count", int'(init_count), mcount % 256);
      if (exp) begin
        mcount++;
        last_t = t;
        have_prev = 1'b1;
      end
      pend = v && !exp;
      hist = {hist[6:0], 1'b0};
      hist[1] = exp;
      t++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R1: start at once after reset, then reset in the middle of a busy run
    run(7'h7F, 4'd8, 1'b0, 4'd1, 20, 1'b0, "R1");
    run(7'h7F, 4'd8, 1'b0, 4'd1, 3, 1'b0, "R1");
    run(7'h7F, 4'd8, 1'b0, 4'd1, 4, 1'b0, "R1");

    // R4: every vector of an 8-cycle pipeline, greedy, irregular requests
    for (int v = 0; v < 128; v++)
      run(7'(v), 4'd8, 1'b0, 4'd1, 24, 1'b1, "R4");

    // R5: length masks upper vector bits
    for (int n = 0; n <= 8; n++) begin
      run(7'h7F, 4'(n), 1'b0, 4'd1, 25, 1'b0, "R5");
      run(7'h55, 4'(n), 1'b0, 4'd1, 25, 1'b1, "R5");
    end

    // R6: fixed latency sweep
    for (int ci = 0; ci < 16; ci++)
      for (int l = 1; l <= 8; l++)
        run(7'((ci * 37 + 5) % 128), 4'd8, 1'b1, 4'(l), 28, 1'b1, "R6");

    // R7: first start not held back by a long fixed latency
    run(7'h00, 4'd8, 1'b1, 4'd8, 12, 1'b0, "R7");

    // R9: greedy versus patient start, unsafe distances 2,4,5
    run(7'b0011010, 4'd8, 1'b0, 4'd1, 21, 1'b0, "R9");
    check(init_count == 8'd6, "R9", "greedy count", int'(init_count), 6);
    run(7'b0011010, 4'd8, 1'b1, 4'd3, 21, 1'b0, "R9");
    check(init_count == 8'd7, "R9", "fixed count", int'(init_count), 7);

    // R8: wrap of the counter
    run(7'h00, 4'd8, 1'b0, 4'd1, 300, 1'b0, "R8");
    check(init_count == 8'd44, "R8", "wrapped count", int'(init_count), 44);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule